// File: doc/BRIEF.md
# Interval List Drain Sorter with Stale-Event Filter

This block takes one bucket of far-future events, read out of external storage in whatever order it was stored, and turns it into a short run of events in time order for the main on-chip event queue. Every event in a bucket belongs to the same fixed slice of simulated time. Events that became invalid after they were stored are not hunted down and deleted. Instead, they are rejected as they stream in. The block keeps a table that records, for each particle, the simulated time of its most recent invalidation. An arriving event is discarded when either of its two particles was invalidated after the event was created.

The events that survive are placed by insertion sort into a small buffer that is always kept in order. The end-of-list marker closes the bucket. The buffer is then emitted, earliest time tag first, and no new bucket is accepted until the buffer is empty. The block also has a purely combinational helper. For a far-future event that is about to be stored, it computes which bucket the event belongs in.

The controller has two states. In ST_FILL it accepts beats and inserts the survivors. The transition FILL→EMIT happens when a beat carrying the end marker is accepted. In ST_EMIT it offers the head of the buffer downstream. The transition EMIT→FILL happens in the cycle after the state machine sees an empty buffer.

Top module: `evq_drain_sorter`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, `ovf_err` is 0, the buffer is empty and all per-particle invalidation times are 0.
- R2: `app_list` equals (`app_time` shifted right by `IVL_SHIFT`) modulo `NUM_LISTS`, combinationally (with defaults: bits [6:4] of `app_time`).
- R3: When `inv_we` is high at a clock edge, the entry for particle `inv_pid` is overwritten with `inv_time`. Only beats accepted in later cycles see the new value. A beat accepted in the same cycle is judged against the old value.
- R4: An accepted beat is discarded, and the buffer does not grow, when the recorded time of `in_pa` or of `in_pb` is strictly greater than `in_ctime`. Equal times keep the event.
- R5: Surviving events leave on `out_time`/`out_ctime`/`out_pa`/`out_pb` in ascending `out_time` order. Events with equal time tags leave in the order they arrived.
- R6: `in_ready` is 1 only in ST_FILL while the buffer holds fewer than `DEPTH` entries. After the end-marker beat is accepted, `in_ready` stays 0 until the cycle after the state machine sees an empty buffer in ST_EMIT.
- R7: In ST_EMIT, `out_valid` is 1 while entries remain. An entry is removed only in a cycle where `out_valid` and `out_ready` are both 1. When `out_ready` is 0, the head is held.
- R8: Once `DEPTH` entries are held in ST_FILL, `in_ready` is 0. Any cycle with `in_valid` high while the buffer is full sets `ovf_err`, which stays set until reset.
- R9: A bucket in which every event is stale produces no output, and `in_ready` returns 2 cycles after the end-marker beat is accepted.
- R10: The beat that carries `in_last` is itself an event: it is filtered and inserted like any other, and it closes the bucket.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| app_time | input | TIME_W | Time tag of an event about to be stored |
| app_list | output | log2(NUM_LISTS) | Bucket index for `app_time` |
| inv_we | input | 1 | Write enable for the invalidation record |
| inv_pid | input | PID_W | Particle whose invalidation time is written |
| inv_time | input | TIME_W | New invalidation time |
| in_valid | input | 1 | Incoming event beat is valid |
| in_ready | output | 1 | Block accepts the beat |
| in_last | input | 1 | Beat is the final event of the bucket |
| in_time | input | TIME_W | Event time tag (sort key) |
| in_ctime | input | TIME_W | Time the event was created |
| in_pa | input | PID_W | First particle of the event |
| in_pb | input | PID_W | Second particle of the event |
| out_valid | output | 1 | Sorted event available |
| out_ready | input | 1 | Downstream takes the event |
| out_time | output | TIME_W | Time tag of the head event |
| out_ctime | output | TIME_W | Creation time of the head event |
| out_pa | output | PID_W | First particle of the head event |
| out_pb | output | PID_W | Second particle of the head event |
| ovf_err | output | 1 | Sticky buffer-overflow flag |

## Verification
Two situations are hard to reach from the ports.

The first is a beat that arrives in the same cycle as an invalidation of one of its own particles. The stimulus arranges this by raising `inv_we` together with `in_valid`, so that this event must still survive. The next beat, which names the same particle, must then be dropped.

The second is overflow, which only happens when a bucket holds more than `DEPTH` fresh events. The stimulus pushes `DEPTH`+1 events with fresh creation times and no end marker. It holds the extra beat against the stalled input for several cycles and then resets the block.

A behavioural model with a sorted queue runs alongside the design and checks the handshake, the flag and the head event on every cycle. Random buckets with random invalidations and random downstream stalls are included.

// File: rtl/evq_drain_pkg.sv
package evq_drain_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_EMIT = 1'b1
    } drain_state_e;

    localparam int DEF_TIME_W = 16;
    localparam int DEF_PID_W  = 4;
    localparam int DEF_DEPTH  = 32;
endpackage

// File: rtl/evq_bucket_index.sv
module evq_bucket_index #(
    parameter int TIME_W    = 16,
    parameter int IVL_SHIFT = 4,
    parameter int NUM_LISTS = 8,
    localparam int LW = (NUM_LISTS > 1) ? $clog2(NUM_LISTS) : 1
) (
    input  logic [TIME_W-1:0] tag,
    output logic [LW-1:0]     list_idx
);
    logic [TIME_W-1:0] slot_num;

    assign slot_num = tag >> IVL_SHIFT;
    assign list_idx = LW'(32'(slot_num) % NUM_LISTS);
endmodule

// File: rtl/evq_stale_table.sv
module evq_stale_table #(
    parameter int TIME_W = 16,
    parameter int PID_W  = 4,
    localparam int NPART = 1 << PID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PID_W-1:0]  wr_id,
    input  logic [TIME_W-1:0] wr_time,
    input  logic [PID_W-1:0]  rd_a,
    input  logic [PID_W-1:0]  rd_b,
    input  logic [TIME_W-1:0] ctime,
    output logic              stale
);
    logic [TIME_W-1:0] inv_q [NPART];

    for (genvar p = 0; p < NPART; p++) begin : g_part
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                inv_q[p] <= '0;
            else if (wr_en && wr_id == PID_W'(p))
                inv_q[p] <= wr_time;
        end
    end

    assign stale = (inv_q[rd_a] > ctime) || (inv_q[rd_b] > ctime);
endmodule

// File: rtl/evq_sort_buf.sv
module evq_sort_buf #(
    parameter int KEY_W = 16,
    parameter int DAT_W = 24,
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins,
    input  logic [KEY_W-1:0] ins_key,
    input  logic [DAT_W-1:0] ins_dat,
    input  logic             pop,
    output logic [KEY_W-1:0] head_key,
    output logic [DAT_W-1:0] head_dat,
    output logic [CW-1:0]    count
);
    logic [KEY_W-1:0] key_q [DEPTH];
    logic [DAT_W-1:0] dat_q [DEPTH];
    logic [CW-1:0]    cnt_q;
    logic [DEPTH-1:0] stay;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [KEY_W-1:0] nxt_key;
        logic [DAT_W-1:0] nxt_dat;
        logic [KEY_W-1:0] sh_key;
        logic [DAT_W-1:0] sh_dat;

        assign stay[i] = (CW'(i) < cnt_q) && (key_q[i] <= ins_key);

        if (i == 0) begin : g_head
            always_comb begin
                if (stay[0]) begin
                    nxt_key = key_q[0];
                    nxt_dat = dat_q[0];
                end else begin
                    nxt_key = ins_key;
                    nxt_dat = ins_dat;
                end
            end
        end else begin : g_body
            always_comb begin
                if (stay[i]) begin
                    nxt_key = key_q[i];
                    nxt_dat = dat_q[i];
                end else if (stay[i-1]) begin
                    nxt_key = ins_key;
                    nxt_dat = ins_dat;
                end else begin
                    nxt_key = key_q[i-1];
                    nxt_dat = dat_q[i-1];
                end
            end
        end

        if (i == DEPTH - 1) begin : g_tail
            assign sh_key = key_q[i];
            assign sh_dat = dat_q[i];
        end else begin : g_mid
            assign sh_key = key_q[i+1];
            assign sh_dat = dat_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (ins) begin
                key_q[i] <= nxt_key;
                dat_q[i] <= nxt_dat;
            end else if (pop) begin
                key_q[i] <= sh_key;
                dat_q[i] <= sh_dat;
            end
        end

        if (i < DEPTH - 1) begin : g_ord
            // R5
            order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (CW'(i + 1) < cnt_q) |-> (key_q[i] <= key_q[i+1]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ins && !pop)
            cnt_q <= cnt_q + 1'b1;
        else if (pop && !ins)
            cnt_q <= cnt_q - 1'b1;
    end

    assign head_key = key_q[0];
    assign head_dat = dat_q[0];
    assign count    = cnt_q;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins |-> (cnt_q != CW'(DEPTH)));
endmodule

// File: rtl/evq_drain_sorter.sv
module evq_drain_sorter
    import evq_drain_pkg::*;
#(
    parameter int TIME_W    = DEF_TIME_W,
    parameter int PID_W     = DEF_PID_W,
    parameter int DEPTH     = DEF_DEPTH,
    parameter int IVL_SHIFT = 4,
    parameter int NUM_LISTS = 8,
    localparam int LW = (NUM_LISTS > 1) ? $clog2(NUM_LISTS) : 1,
    localparam int DW = TIME_W + 2 * PID_W,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] app_time,
    output logic [LW-1:0]     app_list,
    input  logic              inv_we,
    input  logic [PID_W-1:0]  inv_pid,
    input  logic [TIME_W-1:0] inv_time,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_last,
    input  logic [TIME_W-1:0] in_time,
    input  logic [TIME_W-1:0] in_ctime,
    input  logic [PID_W-1:0]  in_pa,
    input  logic [PID_W-1:0]  in_pb,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TIME_W-1:0] out_time,
    output logic [TIME_W-1:0] out_ctime,
    output logic [PID_W-1:0]  out_pa,
    output logic [PID_W-1:0]  out_pb,
    output logic              ovf_err
);
    drain_state_e state_q, state_d;
    logic          stale, accept, ins, pop, full;
    logic [CW-1:0] cnt;
    logic [DW-1:0] head_dat;
    logic          ovf_q;

    evq_bucket_index #(.TIME_W(TIME_W), .IVL_SHIFT(IVL_SHIFT), .NUM_LISTS(NUM_LISTS)) u_index (
        .tag(app_time), .list_idx(app_list)
    );

    evq_stale_table #(.TIME_W(TIME_W), .PID_W(PID_W)) u_stale (
        .clk(clk), .rst_n(rst_n),
        .wr_en(inv_we), .wr_id(inv_pid), .wr_time(inv_time),
        .rd_a(in_pa), .rd_b(in_pb), .ctime(in_ctime), .stale(stale)
    );

    evq_sort_buf #(.KEY_W(TIME_W), .DAT_W(DW), .DEPTH(DEPTH)) u_sort (
        .clk(clk), .rst_n(rst_n),
        .ins(ins), .ins_key(in_time), .ins_dat({in_ctime, in_pa, in_pb}),
        .pop(pop), .head_key(out_time), .head_dat(head_dat), .count(cnt)
    );

    assign full   = (cnt == CW'(DEPTH));
    assign accept = in_valid && in_ready;
    assign ins    = accept && !stale;
    assign pop    = out_valid && out_ready;
    assign {out_ctime, out_pa, out_pb} = head_dat;
    assign ovf_err = ovf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_FILL;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (accept && in_last) state_d = ST_EMIT;
            ST_EMIT: if (cnt == '0) state_d = ST_FILL;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_FILL: in_ready  = !full;
            ST_EMIT: out_valid = (cnt != '0);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf_q <= 1'b0;
        else if (state_q == ST_FILL && full && in_valid)
            ovf_q <= 1'b1;
    end

    // R6
    emit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMIT && cnt != '0) |=> (state_q == ST_EMIT));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R4
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && stale) |=> (cnt == $past(cnt)));

    // R7
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (cnt + 1'b1 == $past(cnt)));
endmodule

// File: tb/test_evq_drain_sorter.sv
module test_evq_drain_sorter;
    localparam int TW = 16, PW = 4, DEPTH = 32, SHIFT = 4, NL = 8, LW = 3, NP = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic [TW-1:0] app_time;
    logic [LW-1:0] app_list;
    logic          inv_we;
    logic [PW-1:0] inv_pid;
    logic [TW-1:0] inv_time;
    logic          in_valid, in_ready, in_last;
    logic [TW-1:0] in_time, in_ctime;
    logic [PW-1:0] in_pa, in_pb;
    logic          out_valid, out_ready;
    logic [TW-1:0] out_time, out_ctime;
    logic [PW-1:0] out_pa, out_pb;
    logic          ovf_err;

    evq_drain_sorter #(.TIME_W(TW), .PID_W(PW), .DEPTH(DEPTH), .IVL_SHIFT(SHIFT), .NUM_LISTS(NL))
    i_evq_drain_sorter (
        .clk(clk), .rst_n(rst_n), .app_time(app_time), .app_list(app_list),
        .inv_we(inv_we), .inv_pid(inv_pid), .inv_time(inv_time),
        .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
        .in_time(in_time), .in_ctime(in_ctime), .in_pa(in_pa), .in_pb(in_pb),
        .out_valid(out_valid), .out_ready(out_ready), .out_time(out_time),
        .out_ctime(out_ctime), .out_pa(out_pa), .out_pb(out_pb), .ovf_err(ovf_err)
    );

    int checks = 0, errors = 0;
    string scen = "reset";

    int            m_state;
    logic [TW-1:0] q_t [$];
    logic [TW-1:0] q_c [$];
    logic [PW-1:0] q_a [$];
    logic [PW-1:0] q_b [$];
    logic [TW-1:0] m_inv [NP];
    bit            m_ovf;
    bit            last_acc;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", tag, scen, act, exp);
        end
    endtask

    task automatic model_clear();
        m_state = 0;
        q_t.delete(); q_c.delete(); q_a.delete(); q_b.delete();
        for (int k = 0; k < NP; k++) m_inv[k] = '0;
        m_ovf = 1'b0;
    endtask

    task automatic step();
        bit m_ready, m_ov, acc, stl;
        int sz, p;
        #1;
        m_ready = (m_state == 0) && (q_t.size() < DEPTH);
        m_ov    = (m_state == 1) && (q_t.size() != 0);
        chk("R6", in_ready, m_ready);
        chk("R7", out_valid, m_ov);
        chk("R8", ovf_err, m_ovf);
        chk("R2", app_list, 32'((app_time >> SHIFT) % NL));
        if (m_ov) begin
            chk("R5", out_time, q_t[0]);
            chk("R5", out_ctime, q_c[0]);
            chk("R5", out_pa, q_a[0]);
            chk("R5", out_pb, q_b[0]);
        end
        acc = in_valid && m_ready;
        stl = (m_inv[in_pa] > in_ctime) || (m_inv[in_pb] > in_ctime);
        sz  = q_t.size();
        if (m_state == 0 && sz == DEPTH && in_valid) m_ovf = 1'b1;
        if (acc && !stl) begin
            p = 0;
            while (p < sz && q_t[p] <= in_time) p++;
            q_t.insert(p, in_time); q_c.insert(p, in_ctime);
            q_a.insert(p, in_pa);   q_b.insert(p, in_pb);
        end
        if (m_ov && out_ready) begin
            void'(q_t.pop_front()); void'(q_c.pop_front());
            void'(q_a.pop_front()); void'(q_b.pop_front());
        end
        if (inv_we) m_inv[inv_pid] = inv_time;
        if (m_state == 0 && acc && in_last) m_state = 1;
        else if (m_state == 1 && sz == 0) m_state = 0;
        last_acc = acc;
        @(negedge clk);
        app_time = TW'($urandom);
    endtask

    task automatic send(int t, int c, int a, int b, bit lst);
        in_valid = 1'b1; in_time = TW'(t); in_ctime = TW'(c);
        in_pa = PW'(a); in_pb = PW'(b); in_last = lst;
        do step(); while (!last_acc);
        in_valid = 1'b0; in_last = 1'b0; inv_we = 1'b0;
    endtask

    task automatic drain(bit rnd);
        in_valid = 1'b0;
        for (int n = 0; n < 400 && m_state == 1; n++) begin
            out_ready = rnd ? 1'($urandom % 2) : 1'b1;
            step();
        end
        out_ready = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0; in_last = 1'b0; inv_we = 1'b0; out_ready = 1'b0;
        model_clear();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1", in_ready, 1);
        chk("R1", out_valid, 0);
        chk("R1", ovf_err, 0);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        app_time = '0; inv_pid = '0; inv_time = '0;
        in_time = '0; in_ctime = '0; in_pa = '0; in_pb = '0;
        do_reset();

        scen = "R2 boundaries";
        foreach (app_time[b]) begin
            app_time = TW'(1) << b;
            #1;
            chk("R2", app_list, 32'((app_time >> SHIFT) % NL));
        end
        app_time = '1; #1; chk("R2", app_list, 7);
        @(negedge clk);

        scen = "R5 basic";
        send(50, 1, 1, 2, 0); send(20, 2, 3, 4, 0); send(80, 3, 5, 6, 0);
        send(20, 4, 7, 8, 0); send(5, 5, 9, 10, 1);
        drain(0);

        scen = "R5 ties R7 backpressure";
        send(40, 0, 1, 0, 0); send(40, 0, 2, 0, 0); send(40, 0, 3, 0, 0);
        send(10, 0, 4, 0, 1);
        drain(1);

        scen = "R3 R4 filter";
        inv_we = 1'b1; inv_pid = 4'd3; inv_time = 16'd100;
        step(); inv_we = 1'b0;
        send(30, 99, 3, 0, 0);
        send(31, 100, 3, 1, 0);
        send(32, 50, 2, 3, 0);
        send(33, 200, 4, 5, 0);
        inv_we = 1'b1; inv_pid = 4'd5; inv_time = 16'd300;
        send(34, 250, 5, 6, 0);
        send(35, 250, 6, 5, 1);
        drain(0);

        scen = "R9 all stale";
        send(60, 10, 3, 1, 0); send(61, 10, 2, 3, 0); send(62, 10, 3, 3, 1);
        drain(0);

        scen = "R10 single beat";
        send(7, 500, 0, 1, 1);
        drain(0);

        scen = "random buckets";
        for (int l = 0; l < 4; l++) begin
            for (int e = 0; e < 30; e++) begin
                inv_we   = ($urandom % 3) == 0;
                inv_pid  = PW'($urandom);
                inv_time = TW'($urandom % 1000);
                send(int'($urandom % 256), int'($urandom % 1000),
                     int'($urandom % NP), int'($urandom % NP), e == 29);
            end
            drain(l[0]);
        end

        scen = "R8 overflow";
        do_reset();
        for (int e = 0; e < DEPTH; e++) send(DEPTH - e, 1, 0, 1, 0);
        in_valid = 1'b1; in_time = 16'd999; in_ctime = 16'd1; in_last = 1'b0;
        for (int k = 0; k < 4; k++) step();
        in_valid = 1'b0;
        step();
        do_reset();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule